// File: doc/BRIEF.md
# Address Security Attribute Classifier

This block sorts every bus address into one of three security classes: Secure, Non-secure, or Non-secure Callable. The Callable class marks entry code that less trusted software may branch into. Two sources decide the class. The first is a fixed map, set by a parameter at build time, that gives one class to each top-level address segment. The second is a table of up to eight ranges that software programs. Each range is an inclusive base and an inclusive limit. A range can only lower security, never raise it. When the unit is enabled, any address that no enabled range covers is Secure.

The final class is the more secure of the two results. The order is Secure, then Callable, then Non-secure. Two or more enabled ranges covering the same address is a setup error. Such an address is reported Secure, with no hit. While the unit is disabled, every address is Secure.

Configuration comes through a plain single-cycle write port. Lookups use a valid/ready stream. A request is taken on any cycle where `lk_valid` and `lk_ready` are both high. Its result appears one cycle later on a registered output. That result stays valid and unchanged until `rs_ready` is seen high. `lk_ready` is high when the output stage is empty or is being drained in the same cycle. So a stalled consumer stalls the requester without losing any result. A configuration write affects only lookups taken after the clock edge that performs the write.

Top module: `addr_sec_classifier`

## Requirements
- R1: After reset, `rs_valid` is 0, `lk_ready` is 1, the unit is disabled and every range is disabled.
- R2: A lookup is taken on a clock edge where `lk_valid` and `lk_ready` are both 1. Its result is valid from the next edge. While `rs_valid` is 1 and `rs_ready` is 0, the result holds unchanged and `lk_ready` is 0.
- R3: While the unit is disabled, every lookup returns attribute code 2'b10 (Secure), `rs_hit` 0 and `rs_region` 0, whatever the ranges hold.
- R4: While the unit is enabled, an address covered by no enabled range returns 2'b10 (Secure) with `rs_hit` 0 and `rs_region` 0.
- R5: Ranges work in 32-byte granules. A base write ignores bits [4:0] and treats them as 0. A limit is taken as ending with bits [4:0] all 1. Both ends are inclusive.
- R6: Attribute codes are 2'b00 Non-secure, 2'b01 Callable and 2'b10 Secure. A single enabled range that hits gives 2'b01 if its callable flag is set, and 2'b00 if it is clear.
- R7: Bit 0 of a limit write is the range enable. A disabled range takes no part in lookup.
- R8: An address covered by two or more enabled ranges returns 2'b10, `rs_hit` 0 and `rs_region` 0.
- R9: The fixed map indexes `FIXED_MAP[2*s +: 2]` with segment s = address bits [31:28]. A code of 2'b11 counts as Secure. The result is the numerically larger code of the fixed class and the range class. By default segments 1 and 3 are Callable, segment 14 is Secure, and all others are Non-secure.
- R10: A write sets one item chosen by `cfg_op`. `cfg_op` 0 sets the unit enable from `cfg_data[0]`. 1 sets the base of range `cfg_region` from `cfg_data[31:5]`. 2 sets that range's limit from `cfg_data[31:5]`, its callable flag from `cfg_data[1]` and its enable from `cfg_data[0]`. 3 changes nothing.
- R11: When exactly one enabled range hits, `rs_hit` is 1 and `rs_region` holds that range's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Item selected by the write (R10) |
| cfg_region | input | 3 | Range index for base/limit writes |
| cfg_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_addr | input | 32 | Address to classify |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_attr | output | 2 | Attribute code (R6) |
| rs_hit | output | 1 | Exactly one enabled range covered the address |
| rs_region | output | 3 | Index of the hitting range, else 0 |

## Verification
The bench probes the two ends of each range. The first and last byte of a granule sit inside the range, and the bytes just outside do not. A design that compared full addresses, or did not pad the limit, would miss the final granule or take in a stray byte below the base.

Two overlapping ranges are checked. A design that used a priority encoder there would report the lower-numbered range as a clean hit, instead of Secure with no hit.

Ranges are also placed over a Callable segment and over a Secure segment of the fixed map. A design that let the range win would wrongly lower those addresses to Non-secure.

Two further cases are covered. A result stalled by the consumer must hold steady, and the next request must wait. A range disabled by its limit write, or the whole unit disabled, must revert to Secure.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

  // Numeric order equals security order: larger code is more secure.
  typedef enum logic [1:0] {
    ATTR_NS   = 2'b00,
    ATTR_CALL = 2'b01,
    ATTR_SEC  = 2'b10
  } attr_e;

  typedef enum logic [1:0] {
    OP_CTRL  = 2'b00,
    OP_BASE  = 2'b01,
    OP_LIMIT = 2'b10,
    OP_NONE  = 2'b11
  } cfg_op_e;

  function automatic attr_e attr_from_code(logic [1:0] code);
    return (code == 2'b11) ? ATTR_SEC : attr_e'(code);
  endfunction

  function automatic attr_e attr_max(attr_e a, attr_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sec_region_table.sv
module sec_region_table
  import sec_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int RIDX_W      = 3
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           cfg_we,
  input  logic [1:0]                                     cfg_op,
  input  logic [RIDX_W-1:0]                              cfg_region,
  input  logic [ADDR_W-1:0]                              cfg_data,
  output logic                                           unit_en,
  output logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0]   base_q,
  output logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0]   limit_q,
  output logic [NUM_REGIONS-1:0]                         call_q,
  output logic [NUM_REGIONS-1:0]                         en_q
);

  logic wr_ctrl, wr_base, wr_limit;

  assign wr_ctrl  = cfg_we && (cfg_op == OP_CTRL);
  assign wr_base  = cfg_we && (cfg_op == OP_BASE);
  assign wr_limit = cfg_we && (cfg_op == OP_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)       unit_en <= 1'b0;
    else if (wr_ctrl) unit_en <= cfg_data[0];
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic sel;
    assign sel = (cfg_region == RIDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[r]  <= '0;
        limit_q[r] <= '0;
        call_q[r]  <= 1'b0;
        en_q[r]    <= 1'b0;
      end else if (sel) begin
        if (wr_base) base_q[r] <= cfg_data[ADDR_W-1:GRAN_BITS];
        if (wr_limit) begin
          limit_q[r] <= cfg_data[ADDR_W-1:GRAN_BITS];
          call_q[r]  <= cfg_data[1];
          en_q[r]    <= cfg_data[0];
        end
      end
    end
  end

endmodule

// File: rtl/sec_region_match.sv
module sec_region_match
  import sec_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int RIDX_W      = 3
) (
  input  logic [ADDR_W-1:0]                              addr,
  input  logic                                           unit_en,
  input  logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0]   base_q,
  input  logic [NUM_REGIONS-1:0][ADDR_W-GRAN_BITS-1:0]   limit_q,
  input  logic [NUM_REGIONS-1:0]                         call_q,
  input  logic [NUM_REGIONS-1:0]                         en_q,
  output attr_e                                          region_attr,
  output logic                                           region_hit,
  output logic [RIDX_W-1:0]                              region_idx
);

  localparam int CNT_W = $clog2(NUM_REGIONS + 1);

  logic [ADDR_W-GRAN_BITS-1:0] gran;
  logic [NUM_REGIONS-1:0]      hits;
  logic [CNT_W-1:0]            n_hit;
  logic [RIDX_W-1:0]           idx;

  assign gran = addr[ADDR_W-1:GRAN_BITS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign hits[r] = en_q[r] && (gran >= base_q[r]) && (gran <= limit_q[r]);
  end

  assign n_hit = CNT_W'($countones(hits));

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hits[i]) idx = RIDX_W'(i);
    end
  end

  always_comb begin
    region_attr = ATTR_SEC;
    region_hit  = 1'b0;
    region_idx  = '0;
    if (unit_en && (n_hit == CNT_W'(1))) begin
      region_attr = call_q[idx] ? ATTR_CALL : ATTR_NS;
      region_hit  = 1'b1;
      region_idx  = idx;
    end
  end

endmodule

// File: rtl/sec_fixed_map.sv
module sec_fixed_map
  import sec_attr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 4,
  parameter logic [2*(1<<SEG_BITS)-1:0] FIXED_MAP = 32'h2000_0044
) (
  input  logic [ADDR_W-1:0] addr,
  output attr_e             fixed_attr
);

  logic [SEG_BITS-1:0] seg;

  assign seg        = addr[ADDR_W-1 -: SEG_BITS];
  assign fixed_attr = attr_from_code(FIXED_MAP[2*seg +: 2]);

endmodule

// File: rtl/addr_sec_classifier.sv
module addr_sec_classifier
  import sec_attr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int GRAN_BITS   = 5,
  parameter int SEG_BITS    = 4,
  parameter logic [2*(1<<SEG_BITS)-1:0] FIXED_MAP = 32'h2000_0044,
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_op,
  input  logic [RIDX_W-1:0] cfg_region,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [1:0]        rs_attr,
  output logic              rs_hit,
  output logic [RIDX_W-1:0] rs_region
);

  localparam int GW = ADDR_W - GRAN_BITS;

  logic                            unit_en;
  logic [NUM_REGIONS-1:0][GW-1:0]  base_q, limit_q;
  logic [NUM_REGIONS-1:0]          call_q, en_q;
  attr_e                           region_attr, fixed_attr, final_attr;
  logic                            region_hit;
  logic [RIDX_W-1:0]               region_idx;
  logic                            accept;

  sec_region_table #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
    .GRAN_BITS(GRAN_BITS), .RIDX_W(RIDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_region(cfg_region), .cfg_data(cfg_data), .unit_en(unit_en),
    .base_q(base_q), .limit_q(limit_q), .call_q(call_q), .en_q(en_q)
  );

  sec_region_match #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
    .GRAN_BITS(GRAN_BITS), .RIDX_W(RIDX_W)
  ) u_match (
    .addr(lk_addr), .unit_en(unit_en), .base_q(base_q), .limit_q(limit_q),
    .call_q(call_q), .en_q(en_q), .region_attr(region_attr),
    .region_hit(region_hit), .region_idx(region_idx)
  );

  sec_fixed_map #(
    .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .FIXED_MAP(FIXED_MAP)
  ) u_fixed (
    .addr(lk_addr), .fixed_attr(fixed_attr)
  );

  assign final_attr = attr_max(fixed_attr, region_attr);
  assign lk_ready   = !rs_valid || rs_ready;
  assign accept     = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_attr   <= ATTR_SEC;
      rs_hit    <= 1'b0;
      rs_region <= '0;
    end else if (accept) begin
      rs_valid  <= 1'b1;
      rs_attr   <= final_attr;
      rs_hit    <= region_hit;
      rs_region <= region_idx;
    end else if (rs_ready) begin
      rs_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/sec_attr_chk.sv
module sec_attr_chk #(
  parameter int RIDX_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [1:0]        rs_attr,
  input logic              rs_hit,
  input logic [RIDX_W-1:0] rs_region,
  input logic              unit_en
);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_attr) && $stable(rs_hit) && $stable(rs_region));

  // R2
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  // R2
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |-> !lk_ready);

  // R3
  disabled_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && !unit_en |=> rs_attr == 2'b10 && !rs_hit && rs_region == '0);

  // R8
  miss_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_attr == 2'b10 && rs_region == '0);

  // R6
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> rs_attr != 2'b11);

endmodule

bind addr_sec_classifier sec_attr_chk #(.RIDX_W(RIDX_W)) u_sec_attr_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_attr(rs_attr),
  .rs_hit(rs_hit), .rs_region(rs_region), .unit_en(unit_en)
);

// File: tb/test_addr_sec_classifier.sv
module test_addr_sec_classifier;

  localparam logic [1:0] A_NS = 2'b00, A_CALL = 2'b01, A_SEC = 2'b10;
  localparam logic [1:0] OPC = 2'd0, OPB = 2'd1, OPL = 2'd2, OPN = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_op = '0;
  logic [2:0]  cfg_region = '0;
  logic [31:0] cfg_data = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic [1:0]  rs_attr;
  logic        rs_hit;
  logic [2:0]  rs_region;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  addr_sec_classifier i_addr_sec_classifier (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_region(cfg_region), .cfg_data(cfg_data), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_attr(rs_attr), .rs_hit(rs_hit),
    .rs_region(rs_region)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_res(string tag, logic [1:0] ea, logic eh, logic [2:0] er);
    checks++;
    if (rs_valid !== 1'b1 || rs_attr !== ea || rs_hit !== eh || rs_region !== er) begin
      errors++;
      $display("FAIL %s: got v=%0b attr=%0b hit=%0b reg=%0d expected v=1 attr=%0b hit=%0b reg=%0d",
               tag, rs_valid, rs_attr, rs_hit, rs_region, ea, eh, er);
    end
  endtask

  task automatic cfg(logic [1:0] op, logic [2:0] r, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_op = op; cfg_region = r; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic lookup(string tag, logic [31:0] a, logic [1:0] ea, logic eh, logic [2:0] er);
    @(negedge clk);
    lk_addr = a; lk_valid = 1'b1;
    @(posedge clk); #1;
    lk_valid = 1'b0;
    @(negedge clk);
    check_res(tag, ea, eh, er);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_bit("R1 rs_valid after reset", rs_valid, 1'b0);
    check_bit("R1 lk_ready after reset", lk_ready, 1'b1);
    lookup("R1 unit disabled after reset", 32'h2004_0000, A_SEC, 1'b0, 3'd0);
  endtask

  task automatic t_disabled_ignores_regions;
    cfg(OPB, 3'd2, 32'h2004_001F);
    cfg(OPL, 3'd2, 32'h200B_FFE1);
    lookup("R3 disabled unit ignores enabled range", 32'h2004_0000, A_SEC, 1'b0, 3'd0);
  endtask

  task automatic t_default_secure;
    cfg(OPC, 3'd0, 32'h1);
    lookup("R4 uncovered address is secure", 32'h4000_0100, A_SEC, 1'b0, 3'd0);
  endtask

  task automatic t_granule_edges;
    lookup("R5 base edge (low bits of base ignored)", 32'h2004_0000, A_NS, 1'b1, 3'd2);
    lookup("R5 limit granule last byte", 32'h200B_FFFF, A_NS, 1'b1, 3'd2);
    lookup("R5 below base", 32'h2003_FFFF, A_SEC, 1'b0, 3'd0);
    lookup("R5 above limit", 32'h200C_0000, A_SEC, 1'b0, 3'd0);
  endtask

  task automatic t_callable;
    cfg(OPB, 3'd0, 32'h0C0F_E000);
    cfg(OPL, 3'd0, 32'h0C0F_FFE3);
    lookup("R6 callable range", 32'h0C0F_E010, A_CALL, 1'b1, 3'd0);
  endtask

  task automatic t_backpressure;
    repeat (2) @(negedge clk);
    rs_ready = 1'b0; lk_addr = 32'h0C0F_E010; lk_valid = 1'b1;
    #1 check_bit("R2 ready when output empty", lk_ready, 1'b1);
    @(posedge clk); #1;
    lk_addr = 32'h4000_0000;
    @(negedge clk);
    check_bit("R2 stalled output blocks request", lk_ready, 1'b0);
    check_res("R2 first result under stall", A_CALL, 1'b1, 3'd0);
    @(negedge clk);
    check_res("R2 result holds while stalled", A_CALL, 1'b1, 3'd0);
    rs_ready = 1'b1;
    @(posedge clk); #1;
    lk_valid = 1'b0;
    @(negedge clk);
    check_res("R2 second result after release", A_SEC, 1'b0, 3'd0);
  endtask

  task automatic t_fixed_map;
    cfg(OPB, 3'd3, 32'h1000_0000);
    cfg(OPL, 3'd3, 32'h1FFF_FFE1);
    lookup("R9 callable segment beats ns range", 32'h1800_0000, A_CALL, 1'b1, 3'd3);
    cfg(OPB, 3'd5, 32'hE000_0000);
    cfg(OPL, 3'd5, 32'hE000_0FE1);
    lookup("R9 secure segment beats ns range", 32'hE000_0040, A_SEC, 1'b1, 3'd5);
  endtask

  task automatic t_overlap;
    cfg(OPB, 3'd4, 32'h0C0F_F000);
    cfg(OPL, 3'd4, 32'h0C10_0FE1);
    lookup("R8 overlapping ranges", 32'h0C0F_F800, A_SEC, 1'b0, 3'd0);
    lookup("R11 single hit reports index", 32'h0C10_0800, A_NS, 1'b1, 3'd4);
  endtask

  task automatic t_noop_write;
    cfg(OPN, 3'd0, 32'h0);
    lookup("R10 op 3 changes nothing", 32'h0C0F_E010, A_CALL, 1'b1, 3'd0);
  endtask

  task automatic t_region_disable;
    cfg(OPL, 3'd2, 32'h200B_FFE0);
    lookup("R7 disabled range ignored", 32'h2004_0000, A_SEC, 1'b0, 3'd0);
  endtask

  task automatic t_unit_disable;
    cfg(OPC, 3'd0, 32'h0);
    lookup("R3 unit disabled again", 32'h0C0F_E010, A_SEC, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_disabled_ignores_regions;
    t_default_secure;
    t_granule_edges;
    t_callable;
    t_backpressure;
    t_fixed_map;
    t_overlap;
    t_noop_write;
    t_region_disable;
    t_unit_disable;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule